// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block holds a handful of byte-wide configuration registers that a host reaches through a serial peripheral port. Each access is one frame while chip select is low. The frame is 16 serial clock cycles long. The first byte is an instruction that names the register and says whether this is a read or a write. The second byte is the data, which the host shifts in on a write or which the block shifts out on a read. The serial lines are brought into the block's own clock domain, and every action happens on detected serial clock edges.

Register 0 controls the port itself. One bit reverses the bit order of both bytes. Another bit moves read data from the dedicated output pin onto the shared data line, and the direction of that line is brought out as an enable. A third bit acts as a software reset: it returns every register except register 0 to its default and always reads back as 0. The active-low reset pin returns every register, register 0 included, to its default. The full register contents are presented in parallel on one output bus.

Top module: `cfg_spi_regbank`

## Requirements
- R1: While `rst_n` is low and after it is released, register 0 holds 0x08, registers 1 to 4 hold 0x00, `spi_sdio_oe` is 0, and the port works MSB-first in four-wire mode.
- R2: A frame is 16 serial clock cycles with chip select low. Data is sampled on rising edges and read data changes after falling edges. Instruction bit 7 set to 1 means a read and 0 means a write. Instruction bits 6:0 hold the register address. The data byte follows the instruction.
- R3: With register 0 bit 6 clear, both bytes travel most significant bit first. With it set, both bytes travel least significant bit first.
- R4: With register 0 bit 7 clear, read data appears on `spi_sdo`. With it set, read data appears on `spi_sdio_o` and `spi_sdo` stays 0.
- R5: `spi_sdio_oe` is 1 only during the data byte of a read in three-wire mode. It is 0 during the instruction byte, during writes, in four-wire mode and after chip select rises.
- R6: A change to register 0 bit 6 or bit 7 takes effect from the frame after the write, once chip select has been high.
- R7: Writing register 0 with bit 5 set returns registers 1 to 4 to their defaults. Register 0 stores the written value with bit 5 cleared. Register 0 bit 5 always reads 0.
- R8: Only these bits can be written: register 0 mask 0xDF, register 1 mask 0xBF, register 3 mask 0x33, registers 2 and 4 mask 0xFF. Bits outside the mask read 0.
- R9: A write to an address of 5 or higher changes nothing. A read from such an address returns 0x00.
- R10: A write frame that ends before its 16th rising serial clock edge changes no register.
- R11: `cfg_o` shows register i on bits [8i+7:8i]. It shows each completed write before chip select is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset pin, resets all registers |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_sdio_i | input | 1 | Serial data into the block (both modes) |
| spi_sdio_o | output | 1 | Read data for the shared line in three-wire mode |
| spi_sdio_oe | output | 1 | Drive enable for the shared line |
| spi_sdo | output | 1 | Read data output in four-wire mode |
| cfg_o | output | 40 | All register contents, register i at [8i+7:8i] |

## Verification
Serial inputs pass through two synchronizer stages and one edge-detect register. A read bit therefore reaches its output pin about four system clocks after the falling serial clock edge that shifts it. The bench holds each half serial clock period for eight system clocks and samples read data and `spi_sdio_oe` on the falling system clock edge just before it raises `spi_sclk`. A write reaches `cfg_o` about four system clocks after the 16th rising edge. The bench therefore compares `cfg_o` only after it has raised chip select and waited twelve more clocks. A mode change is checked in the frame that follows the write, never inside it.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CTRL_IDX   = 0;
  localparam int BIT_SRST   = 5;
  localparam int BIT_LSB    = 6;
  localparam int BIT_3W     = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  // next value of a receive shifter for the chosen bit order
  function automatic byte_t shift_in(byte_t cur, logic b, logic lsb);
    return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
  endfunction

  // advance a transmit shifter by one bit
  function automatic byte_t shift_out(byte_t cur, logic lsb);
    return lsb ? {1'b0, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], 1'b0};
  endfunction

  // bit currently presented by a transmit shifter
  function automatic logic out_bit(byte_t cur, logic lsb);
    return lsb ? cur[0] : cur[BYTE_W-1];
  endfunction

  function automatic byte_t reg_default(int idx);
    return (idx == CTRL_IDX) ? 8'h08 : 8'h00;
  endfunction

  function automatic byte_t reg_wmask(int idx);
    case (idx)
      0:       return 8'hDF;
      1:       return 8'hBF;
      3:       return 8'h33;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  localparam int NSIG = 3;
  localparam int IX_SDI = 0;
  localparam int IX_CS  = 1;
  localparam int IX_CLK = 2;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_d;

  assign raw = {sclk_i, ~csn_i, sdi_i};

  for (genvar s = 0; s < NSIG; s++) begin : g_sync
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {q[STAGES-2:0], raw[s]};
    end
    assign synced[s] = q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[IX_CLK];
  end

  assign cs_act    = synced[IX_CS];
  assign sdi_s     = synced[IX_SDI];
  assign sclk_rise = cs_act &  synced[IX_CLK] & ~sclk_d;
  assign sclk_fall = cs_act & ~synced[IX_CLK] &  sclk_d;
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              sdi,
  input  logic              ctrl_lsb_i,
  input  logic              ctrl_3w_i,
  input  byte_t             rd_data_i,
  output logic              mode_lsb,
  output logic              mode_3w,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr,
  output byte_t             wr_data,
  output logic              drive,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  byte_t            ins_q, rx_q, tx_q;
  logic             drive_q, lsb_q, tw_q;
  logic             instr_done, is_read, rd_load;

  assign instr_done = (cnt_q >= CNT_BYTE);
  assign is_read    = ins_q[BYTE_W-1];
  assign addr       = ins_q[ADDR_W-1:0];
  assign wr_data    = shift_in(rx_q, sdi, lsb_q);
  assign wr_stb     = sclk_rise & (cnt_q == CNT_LAST) & ~is_read;
  assign rd_load    = sclk_fall & (cnt_q == CNT_BYTE) & is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ins_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      drive_q <= 1'b0;
      lsb_q   <= 1'b0;
      tw_q    <= 1'b0;
    end else if (!cs_act) begin
      cnt_q   <= '0;
      ins_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      drive_q <= 1'b0;
      lsb_q   <= ctrl_lsb_i;
      tw_q    <= ctrl_3w_i;
    end else begin
      if (sclk_rise && cnt_q < CNT_END) begin
        cnt_q <= cnt_q + 1'b1;
        if (!instr_done) ins_q <= shift_in(ins_q, sdi, lsb_q);
        else             rx_q  <= wr_data;
      end
      if (rd_load) begin
        tx_q    <= rd_data_i;
        drive_q <= 1'b1;
      end else if (sclk_fall && drive_q) begin
        tx_q <= shift_out(tx_q, lsb_q);
      end
    end
  end

  assign mode_lsb = lsb_q;
  assign mode_3w  = tw_q;
  assign drive    = drive_q;
  assign tx_bit   = out_bit(tx_q, lsb_q);
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          addr,
  input  byte_t                      wr_data,
  output byte_t                      rd_data,
  output logic                       soft_rst,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  assign soft_rst = wr_stb & (addr == ADDR_W'(CTRL_IDX)) & wr_data[BIT_SRST];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reg_default(g);
      else if (wr_stb && addr == ADDR_W'(g))
        q <= wr_data & reg_wmask(g);
      else if (soft_rst && g != CTRL_IDX)
        q <= reg_default(g);
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = regs_flat[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_csn,
  input  logic                       spi_sclk,
  input  logic                       spi_sdio_i,
  output logic                       spi_sdio_o,
  output logic                       spi_sdio_oe,
  output logic                       spi_sdo,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  logic              sclk_rise, sclk_fall, cs_act, sdi_s;
  logic              mode_lsb, mode_3w, wr_stb, soft_rst, drive, tx_bit;
  logic [ADDR_W-1:0] addr;
  byte_t             wr_data, rd_data;

  cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .csn_i     (spi_csn),
    .sdi_i     (spi_sdio_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .sdi_s     (sdi_s)
  );

  cfg_spi_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_act     (cs_act),
    .sdi        (sdi_s),
    .ctrl_lsb_i (cfg_o[CTRL_IDX*BYTE_W + BIT_LSB]),
    .ctrl_3w_i  (cfg_o[CTRL_IDX*BYTE_W + BIT_3W]),
    .rd_data_i  (rd_data),
    .mode_lsb   (mode_lsb),
    .mode_3w    (mode_3w),
    .wr_stb     (wr_stb),
    .addr       (addr),
    .wr_data    (wr_data),
    .drive      (drive),
    .tx_bit     (tx_bit)
  );

  cfg_spi_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .soft_rst  (soft_rst),
    .regs_flat (cfg_o)
  );

  assign spi_sdio_oe = drive & mode_3w;
  assign spi_sdio_o  = spi_sdio_oe & tx_bit;
  assign spi_sdo     = drive & ~mode_3w & tx_bit;
endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_act,
  input logic                       mode_lsb,
  input logic                       mode_3w,
  input logic                       wr_stb,
  input logic [ADDR_W-1:0]          addr,
  input logic                       soft_rst,
  input logic                       spi_sdio_oe,
  input logic                       spi_sdo,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  // R5
  sdio_oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdio_oe |-> mode_3w);

  // R5
  sdio_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_sdio_oe);

  // R4
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdio_oe |-> !spi_sdo);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |=> $stable({mode_lsb, mode_3w}));

  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_o[NUM_REGS*BYTE_W-1:BYTE_W] == '0));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(addr) >= NUM_REGS) |=> $stable(cfg_o));
endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_act      (cs_act),
  .mode_lsb    (mode_lsb),
  .mode_3w     (mode_3w),
  .wr_stb      (wr_stb),
  .addr        (addr),
  .soft_rst    (soft_rst),
  .spi_sdio_oe (spi_sdio_oe),
  .spi_sdo     (spi_sdo),
  .cfg_o       (cfg_o)
);

// File: tb/cfg_spi_regbank_bench.sv
`timescale 1ns/1ps
module cfg_spi_regbank_bench;
  localparam int NREG = 5;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_sdio_i = 1'b0;
  logic spi_sdio_o, spi_sdio_oe, spi_sdo;
  logic [NREG*8-1:0] cfg_o;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic [7:0] model [NREG];
  logic b_lsb = 1'b0;
  logic b_3w  = 1'b0;

  always #2 clk = ~clk;

  cfg_spi_regbank u_cfg_spi_regbank (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o),
    .spi_sdio_oe(spi_sdio_oe), .spi_sdo(spi_sdo), .cfg_o(cfg_o)
  );

  function automatic logic [7:0] exp_default(int i);
    return (i == 0) ? 8'h08 : 8'h00;
  endfunction

  function automatic logic [7:0] exp_mask(int i);
    if (i == 0) return 8'hDF;
    if (i == 1) return 8'hBF;
    if (i == 3) return 8'h33;
    return 8'hFF;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) model[i] = exp_default(i);
    b_lsb = 1'b0;
    b_3w  = 1'b0;
  endtask

  task automatic check_cfg(input string req);
    for (int i = 0; i < NREG; i++) check(req, $sformatf("cfg_o reg%0d", i), 32'(cfg_o[8*i +: 8]), 32'(model[i]));
  endtask

  // one frame of nbits serial clocks; returns the read byte
  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rdv);
    logic [7:0] ins;
    ins = {rd, a};
    rdv = 8'h00;
    spi_csn = 1'b0;
    wait_clk(8);
    for (int k = 0; k < nbits; k++) begin
      int pos;
      pos = b_lsb ? (k % 8) : (7 - (k % 8));
      spi_sdio_i = (k < 8) ? ins[pos] : (rd ? 1'b0 : wd[pos]);
      wait_clk(HALF);
      if (k >= 8 && rd) begin
        rdv[pos] = b_3w ? spi_sdio_o : spi_sdo;
        check("R5", "oe in read data phase", 32'(spi_sdio_oe), 32'(b_3w));
        if (b_3w) check("R4", "sdo idle in three-wire", 32'(spi_sdo), 32'h0);
      end else begin
        check("R5", "oe outside read data", 32'(spi_sdio_oe), 32'h0);
      end
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(12);
    check("R5", "oe after frame", 32'(spi_sdio_oe), 32'h0);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] dummy;
    xfer(1'b0, a, d, 16, dummy);
    if (int'(a) == 0) begin
      model[0] = d & exp_mask(0);
      if (d[5]) for (int i = 1; i < NREG; i++) model[i] = exp_default(i);
      b_lsb = model[0][6];
      b_3w  = model[0][7];
    end else if (int'(a) < NREG) begin
      model[a] = d & exp_mask(int'(a));
    end
    check_cfg(req);
    check_cfg("R11");
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    logic [7:0] v;
    logic [7:0] e;
    xfer(1'b1, a, 8'h00, 16, v);
    e = (int'(a) < NREG) ? model[a] : 8'h00;
    check(req, $sformatf("read addr %0h", a), 32'(v), 32'(e));
  endtask

  task automatic random_pass(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = 7'($urandom_range(6, 1));
      d = 8'($urandom);
      do_write(a, d, req);
      do_read(a, req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tmp;
    void'($urandom(32'h5EED_1234));
    model_reset();
    wait_clk(5);
    // R1: defaults while reset is held
    check_cfg("R1");
    check("R1", "oe in reset", 32'(spi_sdio_oe), 32'h0);
    rst_n = 1'b1;
    wait_clk(5);
    check_cfg("R1");
    check("R1", "sdo after reset", 32'(spi_sdo), 32'h0);

    // R2: basic frames, MSB-first four-wire
    do_read(7'h00, "R2");
    do_write(7'h02, 8'hA5, "R2");
    do_read(7'h02, "R2");

    // R8: masks
    do_write(7'h01, 8'hFF, "R8");
    do_read(7'h01, "R8");
    do_write(7'h03, 8'hFF, "R8");
    do_read(7'h03, "R8");

    // R9: undefined addresses
    do_write(7'h05, 8'h5A, "R9");
    do_write(7'h7F, 8'hC3, "R9");
    do_read(7'h05, "R9");
    do_read(7'h40, "R9");

    // R10: short write frames
    xfer(1'b0, 7'h04, 8'h77, 12, tmp);
    check_cfg("R10");
    xfer(1'b0, 7'h04, 8'h77, 15, tmp);
    check_cfg("R10");

    random_pass(30, "R2");

    // R3 / R6: switch to LSB-first, used from the next frame
    do_write(7'h00, 8'h48, "R6");
    do_read(7'h00, "R6");
    do_write(7'h04, 8'h01, "R3");
    do_read(7'h04, "R3");
    random_pass(15, "R3");

    // R4 / R6: three-wire, still LSB-first
    do_write(7'h00, 8'hC8, "R6");
    do_read(7'h00, "R4");
    random_pass(15, "R4");
    // back to MSB-first in three-wire
    do_write(7'h00, 8'h88, "R6");
    do_read(7'h00, "R6");
    do_write(7'h02, 8'h0F, "R3");
    do_read(7'h02, "R3");

    // R7: software reset keeps register 0
    do_write(7'h02, 8'h3C, "R7");
    do_write(7'h04, 8'h11, "R7");
    do_write(7'h00, 8'hA8, "R7");
    do_read(7'h00, "R7");
    do_read(7'h02, "R7");
    do_read(7'h04, "R7");

    // R1: reset pin restores everything, including register 0
    do_write(7'h03, 8'h21, "R1");
    rst_n = 1'b0;
    wait_clk(4);
    model_reset();
    check_cfg("R1");
    rst_n = 1'b1;
    wait_clk(4);
    do_read(7'h00, "R1");
    do_read(7'h03, "R1");
    random_pass(5, "R2");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule